// File: doc/BRIEF.md
# Parallel EPROM Mode Model

This block is a clocked, synthesizable stand-in for a byte-wide one-time or UV-erasable programmable memory. It is meant to sit on the far side of a device-programmer design under test. The control pins are chip enable, output enable and program strobe, all active low. Two flags mark the programming supply and a high voltage on address line 9. From these pins the model picks one operating mode. In that mode it drives the stored byte, drives an identifier byte, tri-states its outputs, or takes a byte from the bus and clears bits in the addressed location.

The array holds `DEPTH` bytes, and the low address bits index it. Programming works like a real floating-gate part: a pulse only ever turns 1s into 0s. Only the erase input, which stands in for UV exposure, can bring bits back to 1, and the one-time variant (`ERASABLE = 0`) ignores it. A strobe counts as a pulse only when it stays low for `PULSE_MIN` clocks. `WEAK_PULSES` can demand several such pulses on the same address before the bits give, so that a programmer's retry loop can be driven.

The data bus is split into an input, an output and an output-enable. A high `dout_en` means the model drives `dout`. A low `dout_en` stands for high impedance. All control pins are plain levels.

Top module: `eprom_mode_model`

## Requirements
- R1: After reset every location reads 0xFF.
- R2: An effective pulse stores the AND of the old byte and `din`, so a bit at 0 stays 0 until an erase.
- R3: With `ce_n`=0, `oe_n`=0, no programming supply and no high voltage on line 9, `dout_en`=1 and `dout` is the byte at `addr`. In this case `pgm_n` has no effect.
- R4: With no programming supply, `ce_n`=1 or `oe_n`=1 gives `dout_en`=0.
- R5: Program mode is `vpp_hi`=1, `ce_n`=0, `oe_n`=1 and `pgm_n`=0. In this mode `dout_en`=0, and the model writes on the `PULSE_MIN`-th consecutive clock edge spent in the mode.
- R6: Verify mode is `vpp_hi`=1, `ce_n`=0, `oe_n`=0 and `pgm_n`=1. It drives the stored byte.
- R7: With `vpp_hi`=1, a strobe while `ce_n`=1, or `pgm_n`=1 with `oe_n`=1, leaves the array unchanged and gives `dout_en`=0.
- R8: With `a9_hv`=1, `ce_n`=0, `oe_n`=0 and `vpp_hi`=0, the model drives a signature byte if every address bit other than bits 0 and 9 is 0. The byte is 0x97 when `addr[0]`=0 and 0xD6 when `addr[0]`=1. If any of those other bits is 1, `dout_en`=0.
- R9: A strobe that stays low for fewer than `PULSE_MIN` clocks changes nothing.
- R10: When `ERASABLE`=1, a clock edge with `erase`=1 sets every location to 0xFF.
- R11: When `ERASABLE`=0, `erase` has no effect on the array.
- R12: When `WEAK_PULSES`=N>1, bits clear only on the N-th effective pulse in a row to the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, restores blank array |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| pgm_n | input | 1 | Program strobe, active low |
| vpp_hi | input | 1 | Programming supply present |
| a9_hv | input | 1 | High voltage on address line 9 |
| erase | input | 1 | Erase request (UV stand-in) |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Data taken from bus in program mode |
| dout | output | 8 | Data driven onto bus |
| dout_en | output | 1 | Bus driven when 1, high impedance when 0 |

## Verification
The assertions assume that `addr` stays fixed across any two cycles they compare, and that the control pins are steady levels that change only between clock edges. The bench drives every input on the falling edge and holds the address for the whole of a program pulse, so both assumptions hold. The monotonic-bit check also relies on `erase` being low in the cycle it looks back to. The stimulus never raises `erase` during a read that the check watches.

// File: rtl/eprom_pkg.sv
package eprom_pkg;
  typedef enum logic [2:0] {
    MD_STANDBY, MD_OUT_OFF, MD_READ, MD_SIG, MD_PROG, MD_VERIFY, MD_INHIBIT
  } mode_t;
  localparam logic [7:0] SIG_MFR = 8'h97;
  localparam logic [7:0] SIG_DEV = 8'hD6;
  localparam int SIG_PIN = 9;
endpackage

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec
  import eprom_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              pgm_n,
  input  logic              vpp_hi,
  input  logic              a9_hv,
  input  logic [ADDR_W-1:0] addr,
  output mode_t             mode
);
  localparam logic [ADDR_W-1:0] SIG_MASK =
    ~((ADDR_W'(1) << SIG_PIN) | ADDR_W'(1));

  logic rest_low;
  assign rest_low = (addr & SIG_MASK) == '0;

  always_comb begin
    if (ce_n) mode = MD_STANDBY;
    else if (vpp_hi) begin
      if (oe_n && !pgm_n)      mode = MD_PROG;
      else if (!oe_n && pgm_n) mode = MD_VERIFY;
      else                     mode = MD_INHIBIT;
    end else if (oe_n)         mode = MD_OUT_OFF;
    else if (a9_hv)            mode = rest_low ? MD_SIG : MD_OUT_OFF;
    else                       mode = MD_READ;
  end
endmodule

// File: rtl/eprom_pulse_timer.sv
module eprom_pulse_timer #(
  parameter int PULSE_MIN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_prog,
  output logic fire
);
  localparam int CNT_W = $clog2(PULSE_MIN + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSE_MIN - 1);
  localparam logic [CNT_W-1:0] TOP  = CNT_W'(PULSE_MIN);

  logic [CNT_W-1:0] cnt;

  assign fire = in_prog && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!in_prog)   cnt <= '0;
    else if (cnt != TOP) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/eprom_cell_array.sv
module eprom_cell_array #(
  parameter int DEPTH       = 256,
  parameter int IDX_W       = 8,
  parameter int WEAK_PULSES = 1,
  parameter bit ERASABLE    = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             erase,
  input  logic             fire,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata
);
  logic [7:0] mem [DEPTH];
  logic       commit;
  logic       do_erase;

  assign do_erase = ERASABLE && erase;
  assign rdata    = mem[idx];

  generate
    if (WEAK_PULSES <= 1) begin : g_strong
      assign commit = fire;
    end else begin : g_weak
      localparam int HIT_W = $clog2(WEAK_PULSES + 1);
      logic [HIT_W-1:0] hits, hits_new;
      logic [IDX_W-1:0] trk_idx;
      logic             trk_vld;

      assign hits_new = (trk_vld && trk_idx == idx) ? hits + 1'b1 : HIT_W'(1);
      assign commit   = fire && (hits_new >= HIT_W'(WEAK_PULSES));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          hits <= '0; trk_idx <= '0; trk_vld <= 1'b0;
        end else if (do_erase) begin
          hits <= '0; trk_vld <= 1'b0;
        end else if (fire) begin
          trk_idx <= idx;
          trk_vld <= !commit;
          hits    <= commit ? '0 : hits_new;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (do_erase) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (commit) begin
      mem[idx] <= mem[idx] & wdata;
    end
  end
endmodule

// File: rtl/eprom_mode_model.sv
module eprom_mode_model
  import eprom_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int DEPTH       = 256,
  parameter int PULSE_MIN   = 4,
  parameter int WEAK_PULSES = 1,
  parameter bit ERASABLE    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              pgm_n,
  input  logic              vpp_hi,
  input  logic              a9_hv,
  input  logic              erase,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_en
);
  localparam int IDX_W = $clog2(DEPTH);

  mode_t      mode;
  logic       fire;
  logic [7:0] rdata;

  eprom_mode_dec #(.ADDR_W(ADDR_W)) u_dec (
    .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n), .vpp_hi(vpp_hi),
    .a9_hv(a9_hv), .addr(addr), .mode(mode)
  );

  eprom_pulse_timer #(.PULSE_MIN(PULSE_MIN)) u_timer (
    .clk(clk), .rst_n(rst_n), .in_prog(mode == MD_PROG), .fire(fire)
  );

  eprom_cell_array #(
    .DEPTH(DEPTH), .IDX_W(IDX_W), .WEAK_PULSES(WEAK_PULSES), .ERASABLE(ERASABLE)
  ) u_array (
    .clk(clk), .rst_n(rst_n), .erase(erase), .fire(fire),
    .idx(addr[IDX_W-1:0]), .wdata(din), .rdata(rdata)
  );

  always_comb begin
    dout    = 8'h00;
    dout_en = 1'b0;
    case (mode)
      MD_READ, MD_VERIFY: begin dout = rdata; dout_en = 1'b1; end
      MD_SIG: begin dout = addr[0] ? SIG_DEV : SIG_MFR; dout_en = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/eprom_mode_model_chk.sv
module eprom_mode_model_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              pgm_n,
  input logic              vpp_hi,
  input logic              a9_hv,
  input logic              erase,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        dout,
  input logic              dout_en
);
  logic rd_plain, sig_clean;
  assign rd_plain  = !ce_n && !oe_n && !vpp_hi && !a9_hv;
  assign sig_clean = !ce_n && !oe_n && !vpp_hi && a9_hv &&
                     (addr[ADDR_W-1:10] == '0) && (addr[8:1] == '0);

  AST_STANDBY_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n || (oe_n && !vpp_hi)) |-> !dout_en);  // R4
  AST_PROG_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    (vpp_hi && !ce_n && oe_n && !pgm_n) |-> !dout_en);  // R5
  AST_SIG_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    sig_clean |-> (dout_en && dout == (addr[0] ? 8'hD6 : 8'h97)));  // R8
  AST_BITS_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_plain && $past(rd_plain) && $past(rst_n) && !$past(erase) && $stable(addr))
      |-> ((dout & ~$past(dout)) == 8'h00));  // R2
endmodule

bind eprom_mode_model eprom_mode_model_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
  .vpp_hi(vpp_hi), .a9_hv(a9_hv), .erase(erase), .addr(addr),
  .dout(dout), .dout_en(dout_en)
);

// File: tb/eprom_mode_model_test.sv
module eprom_mode_model_test;
  localparam int CLK_NS = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1, vpp_hi = 1'b0, a9_hv = 1'b0, erase = 1'b0;
  logic [16:0] addr = '0;
  logic [7:0]  din = 8'hFF;
  logic [7:0]  dout, o_dout;
  logic        dout_en, o_en;
  int errors = 0, checks = 0;

  always #(CLK_NS/2) clk = ~clk;

  eprom_mode_model uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
    .vpp_hi(vpp_hi), .a9_hv(a9_hv), .erase(erase), .addr(addr), .din(din),
    .dout(dout), .dout_en(dout_en)
  );

  eprom_mode_model #(.WEAK_PULSES(2), .ERASABLE(1'b0)) uut_otp (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
    .vpp_hi(vpp_hi), .a9_hv(a9_hv), .erase(erase), .addr(addr), .din(din),
    .dout(o_dout), .dout_en(o_en)
  );

  typedef struct packed {
    logic ce_n, oe_n, pgm_n, vpp, a9;
    logic [16:0] a;
    logic en;
    logic [7:0] d;
  } vec_t;

  // Taken after address 5 holds 0xA5 and address 6 is still blank.
  localparam vec_t TBL [10] = '{
    '{1'b0,1'b0,1'b1,1'b0,1'b0,17'd5,  1'b1,8'hA5},  // R3 read
    '{1'b0,1'b0,1'b1,1'b0,1'b0,17'd6,  1'b1,8'hFF},  // R1 blank
    '{1'b1,1'b0,1'b1,1'b0,1'b0,17'd5,  1'b0,8'h00},  // R4 standby
    '{1'b0,1'b1,1'b1,1'b0,1'b0,17'd5,  1'b0,8'h00},  // R4 output off
    '{1'b0,1'b0,1'b1,1'b1,1'b0,17'd5,  1'b1,8'hA5},  // R6 verify
    '{1'b0,1'b1,1'b1,1'b1,1'b0,17'd5,  1'b0,8'h00},  // R7 inhibit
    '{1'b0,1'b0,1'b1,1'b0,1'b1,17'd0,  1'b1,8'h97},  // R8 maker
    '{1'b0,1'b0,1'b1,1'b0,1'b1,17'd1,  1'b1,8'hD6},  // R8 device
    '{1'b0,1'b0,1'b1,1'b0,1'b1,17'd8,  1'b0,8'h00},  // R8 stray bit
    '{1'b0,1'b0,1'b0,1'b0,1'b0,17'd5,  1'b1,8'hA5}   // R3 strobe ignored
  };

  task automatic chk(input string req, input logic [8:0] got, input logic [8:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got en/data %h expected %h", req, got, exp);
    end
  endtask

  task automatic set_read(input logic [16:0] a);
    @(negedge clk);
    ce_n = 0; oe_n = 0; pgm_n = 1; vpp_hi = 0; a9_hv = 0; addr = a;
    #1;
  endtask

  // Strobe held low for n rising edges in program mode.
  task automatic pulse(input logic [16:0] a, input logic [7:0] d, input int n, input logic ce);
    @(negedge clk);
    oe_n = 1; pgm_n = 1; a9_hv = 0; vpp_hi = 1; ce_n = ce; addr = a; din = d;
    @(negedge clk);
    pgm_n = 0;
    repeat (n) @(negedge clk);
    pgm_n = 1;
    @(negedge clk);
    vpp_hi = 0; ce_n = 1; din = 8'hFF;
  endtask

  initial begin
    #(CLK_NS * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    set_read(17'd5);
    chk("R1 reset", {dout_en, dout}, {1'b1, 8'hFF});
    chk("R1 reset otp", {o_en, o_dout}, {1'b1, 8'hFF});

    pulse(17'd5, 8'hA5, 4, 1'b0);  // R5 full pulse
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      ce_n = TBL[i].ce_n; oe_n = TBL[i].oe_n; pgm_n = TBL[i].pgm_n;
      vpp_hi = TBL[i].vpp; a9_hv = TBL[i].a9; addr = TBL[i].a;
      #1;
      if (TBL[i].en) chk($sformatf("R3-8 vec %0d", i), {dout_en, dout}, {TBL[i].en, TBL[i].d});
      else           chk($sformatf("R4 hiz vec %0d", i), {8'h00, dout_en}, 9'h000);
    end

    // R5: outputs off while strobing
    @(negedge clk);
    ce_n = 0; oe_n = 1; vpp_hi = 1; pgm_n = 0; addr = 17'd7; din = 8'h00;
    #1;
    chk("R5 hiz in program", {8'h00, dout_en}, 9'h000);
    @(negedge clk);
    pgm_n = 1; vpp_hi = 0;

    pulse(17'd5, 8'h5A, 4, 1'b0);
    set_read(17'd5);
    chk("R2 AND", {dout_en, dout}, {1'b1, 8'h00});

    pulse(17'd6, 8'h00, 3, 1'b0);
    set_read(17'd6);
    chk("R9 short pulse", {dout_en, dout}, {1'b1, 8'hFF});

    pulse(17'd6, 8'h00, 6, 1'b1);
    set_read(17'd6);
    chk("R7 inhibit ce high", {dout_en, dout}, {1'b1, 8'hFF});

    @(negedge clk); erase = 1;
    @(negedge clk); erase = 0;
    set_read(17'd5);
    chk("R10 erase", {dout_en, dout}, {1'b1, 8'hFF});

    pulse(17'd3, 8'h0F, 4, 1'b0);
    set_read(17'd3);
    chk("R12 first pulse weak", {o_en, o_dout}, {1'b1, 8'hFF});
    chk("R5 strong part writes", {dout_en, dout}, {1'b1, 8'h0F});
    pulse(17'd3, 8'h0F, 4, 1'b0);
    set_read(17'd3);
    chk("R12 second pulse", {o_en, o_dout}, {1'b1, 8'h0F});

    @(negedge clk); erase = 1;
    @(negedge clk); erase = 0;
    set_read(17'd3);
    chk("R11 otp erase ignored", {o_en, o_dout}, {1'b1, 8'h0F});
    chk("R10 erase again", {dout_en, dout}, {1'b1, 8'hFF});

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule